// File: doc/BRIEF.md
# Multichannel Tracking State Sequencer

This block schedules the carrier and code loop work of a bank of receiver tracking channels. On every periodic update tick (nominally 0.5 ms) it steps through the channels in ascending index order. Each channel holds one of three modes: off, pull-in or locked tracking. For every channel that is not off, the block issues one loop-update command and then waits for the loop processor to answer with a done strobe. The done strobe carries the channel's synchronization and lock status.

When the answer arrives, the sequencer applies the channel's mode rules. A pull-in channel that gains bit alignment moves to tracking. A pull-in channel that keeps failing is shut down after a programmable number of attempts, and the block raises a reacquisition request. A tracking channel that loses phase lock drops back to pull-in. A tracking channel that reports frame alignment raises a message-decoding request. An acquisition-complete pulse from outside brings an off channel into pull-in. A tick that arrives before the sweep ends flags an overrun and restarts the sweep.

Top module: `trk_seq_top`

## Requirements
- R1: After synchronous reset all channels are off, and `cmd_valid_o`, `reacq_o`, `nav_o` and `overrun_o` are 0.
- R2: Each tick starts a sweep over channels 0 to NUM_CH-1 in ascending order. At most one command is outstanding at a time. A command stays asserted with a stable channel index until `done_i` is sampled high. Every channel that is not off receives exactly one command per sweep.
- R3: A command to a pull-in channel asserts `cmd_code_o`, `cmd_freq_o` and `cmd_phase_o` together.
- R4: A command to a tracking channel asserts `cmd_code_o` and `cmd_phase_o`, with `cmd_freq_o` low.
- R5: An off channel gets no command. A one-cycle `acq_done_i` with index `acq_ch_i` moves an off channel to pull-in and clears its failure count. On a channel that is not off, the pulse has no effect.
- R6: When a pull-in visit completes with `bit_sync_i` high, the channel moves to tracking and its failure count clears.
- R7: When a pull-in visit completes with `bit_sync_i` low, the channel's failure count increases by one. If the new count exceeds `fail_limit_i`, the channel instead turns off and `reacq_o` pulses for one cycle, in the cycle after the done strobe, with the channel index on `event_ch_o`. With a limit of L, the (L+1)-th consecutive failure closes the channel.
- R8: When a tracking visit completes with `phase_lock_i` low, the channel returns to pull-in.
- R9: When a tracking visit completes with `frame_sync_i` high, `nav_o` pulses for one cycle, in the cycle after the done strobe, with the channel index on `event_ch_o`. This happens even if lock is lost in the same visit.
- R10: A tick that arrives while a sweep is in progress pulses `overrun_o` in the following cycle. It drops any outstanding command without a mode change, and the sweep restarts at channel 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | One-cycle update tick that starts a sweep |
| fail_limit_i | input | CNT_W | Pull-in failure threshold |
| acq_done_i | input | 1 | Acquisition-complete pulse |
| acq_ch_i | input | CH_W | Channel named by the acquisition pulse |
| done_i | input | 1 | Loop processor finished the current command |
| bit_sync_i | input | 1 | Bit alignment achieved (sampled with done) |
| frame_sync_i | input | 1 | Frame alignment achieved (sampled with done) |
| phase_lock_i | input | 1 | Phase lock held (sampled with done) |
| cmd_valid_o | output | 1 | Command outstanding |
| cmd_ch_o | output | CH_W | Channel of the outstanding command |
| cmd_code_o | output | 1 | Run code loop update |
| cmd_freq_o | output | 1 | Run frequency loop update |
| cmd_phase_o | output | 1 | Run phase loop update |
| reacq_o | output | 1 | Reacquisition/reinitialization request pulse |
| nav_o | output | 1 | Navigation message task request pulse |
| event_ch_o | output | CH_W | Channel of the current request pulse |
| overrun_o | output | 1 | Tick arrived during an unfinished sweep |

## Verification
The assertions assume that the status inputs are meaningful only in the cycle where `done_i` is high with a command outstanding. They also assume that `done_i` never arrives without a command and that `acq_ch_i` names a real channel. The bench's responder raises `done_i` for exactly one cycle, and only after it has seen `cmd_valid_o`. It drives the status lines from per-channel settings that stay fixed for the whole sweep. It issues acquisition pulses and threshold changes only between sweeps. The overrun case deliberately holds back the done answer so that the second tick lands on an outstanding command.

// File: rtl/trk_seq_pkg.sv
package trk_seq_pkg;

    typedef enum logic [1:0] {
        CH_OFF   = 2'd0,
        CH_PULL  = 2'd1,
        CH_TRACK = 2'd2
    } ch_mode_e;

    typedef enum logic [1:0] {
        SQ_IDLE = 2'd0,
        SQ_SCAN = 2'd1,
        SQ_WAIT = 2'd2
    } sq_state_e;

    typedef struct packed {
        logic bit_sync;
        logic frame_sync;
        logic phase_lock;
    } ch_status_t;

    typedef struct packed {
        ch_mode_e next_mode;
        logic     clr_cnt;
        logic     inc_cnt;
        logic     reacq;
        logic     nav;
    } verdict_t;

    // Mode rules applied when a visit completes.
    function automatic verdict_t judge(input ch_mode_e mode,
                                       input logic over_lim,
                                       input ch_status_t st);
        verdict_t v;
        v.next_mode = mode;
        v.clr_cnt   = 1'b0;
        v.inc_cnt   = 1'b0;
        v.reacq     = 1'b0;
        v.nav       = 1'b0;
        case (mode)
            CH_PULL: begin
                if (st.bit_sync) begin
                    v.next_mode = CH_TRACK;
                    v.clr_cnt   = 1'b1;
                end else if (over_lim) begin
                    v.next_mode = CH_OFF;
                    v.clr_cnt   = 1'b1;
                    v.reacq     = 1'b1;
                end else begin
                    v.inc_cnt   = 1'b1;
                end
            end
            CH_TRACK: begin
                v.nav = st.frame_sync;
                if (!st.phase_lock) v.next_mode = CH_PULL;
            end
            default: ;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/trk_chan_table.sv
module trk_chan_table
    import trk_seq_pkg::*;
#(
    parameter int NUM_CH = 24,
    parameter int CH_W   = 5,
    parameter int CNT_W  = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CH_W-1:0]  rd_ch,
    output ch_mode_e         rd_mode,
    output logic [CNT_W-1:0] rd_cnt,
    input  logic             wr_en,
    input  logic [CH_W-1:0]  wr_ch,
    input  ch_mode_e         wr_mode,
    input  logic [CNT_W-1:0] wr_cnt,
    input  logic             acq_en,
    input  logic [CH_W-1:0]  acq_ch
);

    ch_mode_e         mode_q [NUM_CH];
    logic [CNT_W-1:0] cnt_q  [NUM_CH];

    always_ff @(posedge clk) begin
        for (int i = 0; i < NUM_CH; i++) begin
            if (rst) begin
                mode_q[i] <= CH_OFF;
                cnt_q[i]  <= '0;
            end else if (wr_en && wr_ch == CH_W'(i)) begin
                mode_q[i] <= wr_mode;
                cnt_q[i]  <= wr_cnt;
            end else if (acq_en && acq_ch == CH_W'(i) && mode_q[i] == CH_OFF) begin
                mode_q[i] <= CH_PULL;
                cnt_q[i]  <= '0;
            end
        end
    end

    always_comb begin
        rd_mode = CH_OFF;
        rd_cnt  = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (rd_ch == CH_W'(i)) begin
                rd_mode = mode_q[i];
                rd_cnt  = cnt_q[i];
            end
        end
    end

endmodule

// File: rtl/trk_seq_ctrl.sv
module trk_seq_ctrl
    import trk_seq_pkg::*;
#(
    parameter int NUM_CH = 24,
    parameter int CH_W   = 5,
    parameter int CNT_W  = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_i,
    input  logic             done_i,
    input  ch_status_t       status_i,
    input  logic [CNT_W-1:0] limit_i,
    input  ch_mode_e         cur_mode_i,
    input  logic [CNT_W-1:0] cur_cnt_i,
    output logic [CH_W-1:0]  cur_ch_o,
    output logic             cmd_valid_o,
    output logic             cmd_freq_o,
    output logic             wr_en_o,
    output ch_mode_e         wr_mode_o,
    output logic [CNT_W-1:0] wr_cnt_o,
    output logic             reacq_o,
    output logic             nav_o,
    output logic [CH_W-1:0]  evt_ch_o,
    output logic             overrun_o
);

    localparam logic [CH_W-1:0] LAST_CH = CH_W'(NUM_CH - 1);

    sq_state_e        sq_q;
    logic [CH_W-1:0]  cur_q;
    logic [CNT_W:0]   cnt_inc;
    logic             over_lim;
    logic             visit_end;
    logic             last_ch;
    verdict_t         verdict;

    assign cnt_inc   = {1'b0, cur_cnt_i} + {{CNT_W{1'b0}}, 1'b1};
    assign over_lim  = cnt_inc > {1'b0, limit_i};
    assign verdict   = judge(cur_mode_i, over_lim, status_i);
    assign visit_end = (sq_q == SQ_WAIT) && done_i && !tick_i;
    assign last_ch   = (cur_q == LAST_CH);

    assign cur_ch_o    = cur_q;
    assign cmd_valid_o = (sq_q == SQ_WAIT);
    assign cmd_freq_o  = cmd_valid_o && (cur_mode_i == CH_PULL);

    always_comb begin
        wr_en_o   = visit_end;
        wr_mode_o = verdict.next_mode;
        if (verdict.clr_cnt)      wr_cnt_o = '0;
        else if (verdict.inc_cnt) wr_cnt_o = cnt_inc[CNT_W-1:0];
        else                      wr_cnt_o = cur_cnt_i;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sq_q      <= SQ_IDLE;
            cur_q     <= '0;
            reacq_o   <= 1'b0;
            nav_o     <= 1'b0;
            evt_ch_o  <= '0;
            overrun_o <= 1'b0;
        end else begin
            reacq_o   <= 1'b0;
            nav_o     <= 1'b0;
            overrun_o <= 1'b0;
            if (tick_i) begin
                overrun_o <= (sq_q != SQ_IDLE);
                sq_q      <= SQ_SCAN;
                cur_q     <= '0;
            end else begin
                case (sq_q)
                    SQ_SCAN: begin
                        if (cur_mode_i != CH_OFF) begin
                            sq_q <= SQ_WAIT;
                        end else if (last_ch) begin
                            sq_q <= SQ_IDLE;
                        end else begin
                            cur_q <= cur_q + CH_W'(1);
                        end
                    end
                    SQ_WAIT: begin
                        if (done_i) begin
                            reacq_o  <= verdict.reacq;
                            nav_o    <= verdict.nav;
                            evt_ch_o <= cur_q;
                            if (last_ch) begin
                                sq_q <= SQ_IDLE;
                            end else begin
                                sq_q  <= SQ_SCAN;
                                cur_q <= cur_q + CH_W'(1);
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

endmodule

// File: rtl/trk_seq_top.sv
module trk_seq_top
    import trk_seq_pkg::*;
#(
    parameter int NUM_CH = 24,
    parameter int CNT_W  = 8,
    localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_i,
    input  logic [CNT_W-1:0] fail_limit_i,
    input  logic             acq_done_i,
    input  logic [CH_W-1:0]  acq_ch_i,
    input  logic             done_i,
    input  logic             bit_sync_i,
    input  logic             frame_sync_i,
    input  logic             phase_lock_i,
    output logic             cmd_valid_o,
    output logic [CH_W-1:0]  cmd_ch_o,
    output logic             cmd_code_o,
    output logic             cmd_freq_o,
    output logic             cmd_phase_o,
    output logic             reacq_o,
    output logic             nav_o,
    output logic [CH_W-1:0]  event_ch_o,
    output logic             overrun_o
);

    ch_status_t       status;
    ch_mode_e         cur_mode;
    logic [CNT_W-1:0] cur_cnt;
    logic [CH_W-1:0]  cur_ch;
    logic             wr_en;
    ch_mode_e         wr_mode;
    logic [CNT_W-1:0] wr_cnt;

    assign status = '{bit_sync: bit_sync_i, frame_sync: frame_sync_i,
                      phase_lock: phase_lock_i};

    trk_chan_table #(.NUM_CH(NUM_CH), .CH_W(CH_W), .CNT_W(CNT_W)) u_table (
        .clk     (clk),
        .rst     (rst),
        .rd_ch   (cur_ch),
        .rd_mode (cur_mode),
        .rd_cnt  (cur_cnt),
        .wr_en   (wr_en),
        .wr_ch   (cur_ch),
        .wr_mode (wr_mode),
        .wr_cnt  (wr_cnt),
        .acq_en  (acq_done_i),
        .acq_ch  (acq_ch_i)
    );

    trk_seq_ctrl #(.NUM_CH(NUM_CH), .CH_W(CH_W), .CNT_W(CNT_W)) u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .tick_i      (tick_i),
        .done_i      (done_i),
        .status_i    (status),
        .limit_i     (fail_limit_i),
        .cur_mode_i  (cur_mode),
        .cur_cnt_i   (cur_cnt),
        .cur_ch_o    (cur_ch),
        .cmd_valid_o (cmd_valid_o),
        .cmd_freq_o  (cmd_freq_o),
        .wr_en_o     (wr_en),
        .wr_mode_o   (wr_mode),
        .wr_cnt_o    (wr_cnt),
        .reacq_o     (reacq_o),
        .nav_o       (nav_o),
        .evt_ch_o    (event_ch_o),
        .overrun_o   (overrun_o)
    );

    assign cmd_ch_o    = cur_ch;
    assign cmd_code_o  = cmd_valid_o;
    assign cmd_phase_o = cmd_valid_o;

endmodule

// File: rtl/trk_seq_chk.sv
module trk_seq_chk #(
    parameter int NUM_CH = 24,
    parameter int CNT_W  = 8,
    parameter int CH_W   = 5
) (
    input logic            clk,
    input logic            rst,
    input logic            tick_i,
    input logic            done_i,
    input logic            bit_sync_i,
    input logic            frame_sync_i,
    input logic            cmd_valid_o,
    input logic [CH_W-1:0] cmd_ch_o,
    input logic            cmd_freq_o,
    input logic            reacq_o,
    input logic            nav_o,
    input logic [CH_W-1:0] event_ch_o,
    input logic            overrun_o
);

    localparam logic [CH_W-1:0] TOP_CH = CH_W'(NUM_CH - 1);

    AST_CMD_HELD: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid_o && !done_i && !tick_i) |=> (cmd_valid_o && $stable(cmd_ch_o) && $stable(cmd_freq_o))); // R2
    AST_ONE_AT_A_TIME: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid_o && done_i) |=> !cmd_valid_o); // R2
    AST_CH_RANGE: assert property (@(posedge clk) disable iff (rst)
        cmd_valid_o |-> (cmd_ch_o <= TOP_CH)); // R2
    AST_REACQ_SRC: assert property (@(posedge clk) disable iff (rst)
        reacq_o |-> $past(cmd_valid_o && done_i && cmd_freq_o && !bit_sync_i && !tick_i)); // R7
    AST_REACQ_CH: assert property (@(posedge clk) disable iff (rst)
        reacq_o |-> (event_ch_o == $past(cmd_ch_o))); // R7
    AST_NAV_SRC: assert property (@(posedge clk) disable iff (rst)
        nav_o |-> $past(cmd_valid_o && done_i && !cmd_freq_o && frame_sync_i && !tick_i)); // R9
    AST_EVT_EXCL: assert property (@(posedge clk) disable iff (rst)
        $onehot0({reacq_o, nav_o})); // R7
    AST_OVERRUN_FLAG: assert property (@(posedge clk) disable iff (rst)
        (tick_i && cmd_valid_o) |=> (overrun_o && !cmd_valid_o)); // R10

endmodule

bind trk_seq_top trk_seq_chk #(.NUM_CH(NUM_CH), .CNT_W(CNT_W), .CH_W(CH_W)) u_chk (.*);

// File: tb/tb_trk_seq_top.sv
module tb_trk_seq_top;

    localparam int NCH = 24;
    localparam int CW  = 8;
    localparam int HW  = $clog2(NCH);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          tick_i = 1'b0;
    logic [CW-1:0] fail_limit_i = 8'd2;
    logic          acq_done_i = 1'b0;
    logic [HW-1:0] acq_ch_i = '0;
    logic          done_i = 1'b0;
    logic          bit_sync_i = 1'b0;
    logic          frame_sync_i = 1'b0;
    logic          phase_lock_i = 1'b1;
    logic          cmd_valid_o;
    logic [HW-1:0] cmd_ch_o;
    logic          cmd_code_o, cmd_freq_o, cmd_phase_o;
    logic          reacq_o, nav_o, overrun_o;
    logic [HW-1:0] event_ch_o;

    always #2 clk = ~clk;

    trk_seq_top #(.NUM_CH(NCH), .CNT_W(CW)) dut (.*);

    typedef struct {
        int ch;
        bit freq;
        bit reacq;
        bit nav;
    } item_t;

    item_t q[$];
    int  m_mode [NCH];   // 0 off, 1 pull-in, 2 tracking
    int  m_cnt  [NCH];
    bit  st_bit [NCH];
    bit  st_frm [NCH];
    bit  st_lck [NCH];
    int  n_chk = 0;
    int  n_bad = 0;
    int  cmd_seen = 0;
    bit  hold = 1'b0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Driver: expected visits of the next sweep, from the requirement rules.
    task automatic plan_sweep();
        for (int c = 0; c < NCH; c++) begin
            item_t it;
            if (m_mode[c] != 0) begin
                it.ch = c; it.freq = (m_mode[c] == 1); it.reacq = 0; it.nav = 0;
                if (m_mode[c] == 1) begin
                    if (st_bit[c]) begin
                        m_mode[c] = 2; m_cnt[c] = 0;
                    end else begin
                        m_cnt[c]++;
                        if (m_cnt[c] > int'(fail_limit_i)) begin
                            m_mode[c] = 0; m_cnt[c] = 0; it.reacq = 1;
                        end
                    end
                end else begin
                    it.nav = st_frm[c];
                    if (!st_lck[c]) m_mode[c] = 1;
                end
                q.push_back(it);
            end
        end
    endtask

    task automatic pulse_tick();
        @(negedge clk); tick_i = 1'b1;
        @(negedge clk); tick_i = 1'b0;
    endtask

    task automatic drain();
        repeat (100) @(negedge clk);
        chk(q.size() == 0, "R2 every active channel visited", q.size(), 0);
    endtask

    task automatic sweep();
        plan_sweep();
        pulse_tick();
        drain();
    endtask

    task automatic acq(input int c);
        @(negedge clk); acq_done_i = 1'b1; acq_ch_i = HW'(c);
        @(negedge clk); acq_done_i = 1'b0;
        if (m_mode[c] == 0) begin m_mode[c] = 1; m_cnt[c] = 0; end
    endtask

    // Monitor / responder: pops expected visits and answers each command.
    initial begin
        forever begin
            @(negedge clk);
            if (!hold && !rst) begin
                if (cmd_valid_o) begin
                    item_t it;
                    int c;
                    cmd_seen++;
                    c = int'(cmd_ch_o);
                    if (q.size() == 0) begin
                        chk(1'b0, "R2 unexpected command", c, -1);
                        it.ch = c; it.freq = 0; it.reacq = 0; it.nav = 0;
                    end else begin
                        it = q.pop_front();
                        chk(c == it.ch, "R2 visit order", c, it.ch);
                        chk(cmd_freq_o == it.freq, "R3 R4 frequency loop select", cmd_freq_o, it.freq);
                        chk(cmd_code_o && cmd_phase_o, "R3 R4 code and phase loops", {cmd_code_o, cmd_phase_o}, 3);
                    end
                    done_i = 1'b1;
                    bit_sync_i = st_bit[c]; frame_sync_i = st_frm[c]; phase_lock_i = st_lck[c];
                    @(negedge clk);
                    done_i = 1'b0;
                    chk(reacq_o == it.reacq, "R7 reacquisition pulse", reacq_o, it.reacq);
                    chk(nav_o == it.nav, "R9 message task pulse", nav_o, it.nav);
                    if (it.reacq || it.nav)
                        chk(int'(event_ch_o) == it.ch, "R7 R9 event channel", int'(event_ch_o), it.ch);
                end else if (reacq_o || nav_o) begin
                    chk(1'b0, "R7 R9 stray request", {reacq_o, nav_o}, 0);
                end
            end
        end
    end

    initial begin
        #(4 * 150000);
        chk(1'b0, "watchdog", 0, 1);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        for (int c = 0; c < NCH; c++) begin
            m_mode[c] = 0; m_cnt[c] = 0; st_bit[c] = 0; st_frm[c] = 0; st_lck[c] = 1;
        end
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(!cmd_valid_o, "R1 no command after reset", cmd_valid_o, 0);
        chk(!reacq_o && !nav_o, "R1 no request after reset", {reacq_o, nav_o}, 0);
        chk(!overrun_o, "R1 no overrun after reset", overrun_o, 0);

        sweep();
        chk(cmd_seen == 0, "R5 off channels skipped", cmd_seen, 0);

        acq(3); acq(7); acq(23);
        sweep();                               // R3: all pull-in, first failure
        st_bit[3] = 1; sweep();                // R6: ch3 to tracking
        st_bit[3] = 0; sweep();                // R4 ch3; R7: ch7, ch23 close
        acq(23); sweep();                      // R5: ch7 skipped, ch23 back in pull-in
        acq(3);                                // R5: ignored, ch3 tracking
        st_frm[3] = 1; sweep();                // R9
        st_frm[3] = 0; st_lck[3] = 0; sweep(); // R8: ch3 to pull-in
        st_lck[3] = 1; sweep();                // R3 ch3 again pull-in

        // R10: overrun while ch3 command is outstanding
        hold = 1'b1;
        pulse_tick();
        repeat (8) @(negedge clk);
        chk(cmd_valid_o && int'(cmd_ch_o) == 3, "R10 command outstanding before overrun", int'(cmd_ch_o), 3);
        plan_sweep();
        @(negedge clk); tick_i = 1'b1;
        @(negedge clk); tick_i = 1'b0;
        chk(overrun_o, "R10 overrun flagged", overrun_o, 1);
        chk(!cmd_valid_o, "R10 outstanding command dropped", cmd_valid_o, 0);
        hold = 1'b0;
        drain();
        sweep();
        chk(!overrun_o, "R10 no overrun after orderly sweep", overrun_o, 0);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule